// File: doc/BRIEF.md
# Six-Button Gamepad Port Multiplexer

This block models one controller port as the CPU sees it. A 12-bit vector of pressed buttons comes in active-high. The CPU writes a data register and a direction register, and reads back one byte. Bit 6 of the data register acts as the select line (TH). The block picks which group of buttons shows up in the low six bits. It does this from the TH level and, when six-button mode is on, from a phase counter that follows TH rising edges. Pressed buttons read as 0.

Bits the direction register marks as outputs, and bit 7 always, return what the CPU wrote and not the pad. In six-button mode the third and fourth TH pulses of a burst expose the extra buttons (Mode, X, Y, Z) and an identifying nibble. If TH stops toggling for `IDLE_LIMIT` clock cycles, the phase counter falls back to 0. The button vector is ordered Mode(11) X(10) Y(9) Z(8) Start(7) A(6) C(5) B(4) Right(3) Left(2) Down(1) Up(0).

Top module: `pad_port_mux`

## Requirements
- R1: The pad bits of `rd_data_o` carry the inverse of the button inputs: a pressed (1) button reads as 0.
- R2: For each bit `n` where `port_dir_i[n]` is 1, `rd_data_o[n]` equals `port_data_i[n]`. Bit 7 always equals `port_data_i[7]`. All other bits come from the pad selection.
- R3: Normal selection with TH (`port_data_i[6]`) high: bits 5..0 are the inverted C, B, Right, Left, Down, Up.
- R4: Normal selection with TH low: bits 5..4 are inverted Start, A; bits 3..2 are 0; bits 1..0 are inverted Down, Up.
- R5: Six-button mode, phase 2, TH low: bits 5..4 are inverted Start, A, and bits 3..0 are 0000.
- R6: Six-button mode, phase 3, TH high: bits 5..4 are inverted C, B, and bits 3..0 are inverted Mode, X, Y, Z.
- R7: Six-button mode, phase 3, TH low: bits 5..4 are inverted Start, A, and bits 3..0 are 1111.
- R8: With six-button mode off, the phase has no effect on the read value. With it on, phases 0 and 1 (either TH level) and phase 2 with TH high use the normal selection.
- R9: `phase_o` increments by one on each clock edge where TH is 1 and was 0 at the previous edge, wrapping 3 to 0. Falling or steady TH leaves it unchanged, apart from the timeout.
- R10: When `IDLE_LIMIT` clock edges pass after the last TH rise with no new rise, `phase_o` becomes 0 on the `IDLE_LIMIT`-th edge.
- R11: `rd_data_o[6]` equals TH when `port_dir_i[6]` is 1, and is 0 when it is 0.
- R12: Reset sets `phase_o` to 0 and treats TH as previously high, so TH already high when reset is released is not a rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_i | input | 12 | Buttons, 1 = pressed (M X Y Z S A C B R L D U) |
| port_data_i | input | 8 | Port data register; bit 6 is TH |
| port_dir_i | input | 8 | Port direction register; 1 = output |
| six_btn_i | input | 1 | Six-button mode enable |
| rd_data_o | output | 8 | Byte returned to a CPU read |
| phase_o | output | 2 | Current TH phase |

## Verification
The bench drives each phase with real TH pulse bursts, then reads under both TH levels. A mux keyed to the wrong phase would show Mode/XYZ at phase 2, or leak the 0000/1111 nibbles into normal mode. The output merge is tested with outputs on pad bits and on TH. A design that ORed pad bits with the data register, or kept bit 6 at 0, would fail there. The timeout is sampled one edge before and one edge at the limit, which catches an off-by-one in the idle counter. A reset check with TH high catches a history register that resets low and invents a phase step.

// File: rtl/pad_port_mux.sv
module pad_port_mux #(
  parameter int unsigned IDLE_LIMIT = 300000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] btn_i,
  input  logic [7:0]  port_data_i,
  input  logic [7:0]  port_dir_i,
  input  logic        six_btn_i,
  output logic [7:0]  rd_data_o,
  output logic [1:0]  phase_o
);
  localparam int unsigned CW = (IDLE_LIMIT > 2) ? $clog2(IDLE_LIMIT) : 1;
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_LIMIT - 1);

  logic          th_q;
  logic [1:0]    phase_q;
  logic [CW-1:0] idle_q;
  logic [11:0]   lvl;
  logic [5:0]    pad;
  logic [7:0]    out_mask;

  wire th      = port_data_i[6];
  wire th_rise = th & ~th_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      th_q    <= 1'b1;
      phase_q <= 2'd0;
      idle_q  <= '0;
    end else begin
      th_q <= th;
      if (th_rise) begin
        phase_q <= phase_q + 2'd1;
        idle_q  <= '0;
      end else if (idle_q == IDLE_LAST) begin
        phase_q <= 2'd0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign lvl = ~btn_i;

  always_comb begin
    if (six_btn_i && phase_q == 2'd3 && th)
      pad = {lvl[5], lvl[4], lvl[11], lvl[10], lvl[9], lvl[8]};
    else if (six_btn_i && phase_q == 2'd3)
      pad = {lvl[7], lvl[6], 4'hF};
    else if (six_btn_i && phase_q == 2'd2 && !th)
      pad = {lvl[7], lvl[6], 4'h0};
    else if (th)
      pad = lvl[5:0];
    else
      pad = {lvl[7], lvl[6], 2'b00, lvl[1:0]};
  end

  assign out_mask  = port_dir_i | 8'h80;
  assign rd_data_o = (port_data_i & out_mask) | ({2'b00, pad} & ~out_mask);
  assign phase_o   = phase_q;
endmodule

// File: rtl/pad_port_mux_chk.sv
module pad_port_mux_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] btn_i,
  input logic [7:0]  port_data_i,
  input logic [7:0]  port_dir_i,
  input logic        six_btn_i,
  input logic [7:0]  rd_data_o,
  input logic [1:0]  phase_o
);
  AST_BIT7_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[7] == port_data_i[7]); // R2

  AST_TH_OUT_BIT6: assert property (@(posedge clk) disable iff (!rst_n)
    port_dir_i[6] |-> rd_data_o[6] == port_data_i[6]); // R11

  AST_TH_IN_BIT6_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !port_dir_i[6] |-> rd_data_o[6] == 1'b0); // R11

  AST_PH3_HI_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (six_btn_i && phase_o == 2'd3 && port_data_i[6] && port_dir_i[3:0] == 4'h0)
      |-> rd_data_o[3:0] == ~btn_i[11:8]); // R6

  AST_PH3_LO_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (six_btn_i && phase_o == 2'd3 && !port_data_i[6] && port_dir_i[3:0] == 4'h0)
      |-> rd_data_o[3:0] == 4'hF); // R7

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && port_data_i[6] && !$past(port_data_i[6]))
      |=> phase_o == 2'($past(phase_o) + 2'd1)); // R9

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !(port_data_i[6] && !$past(port_data_i[6])))
      |=> (phase_o == $past(phase_o) || phase_o == 2'd0)); // R9
endmodule

bind pad_port_mux pad_port_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .port_data_i(port_data_i),
  .port_dir_i(port_dir_i), .six_btn_i(six_btn_i), .rd_data_o(rd_data_o),
  .phase_o(phase_o)
);

// File: tb/pad_port_mux_tb.sv
`timescale 1ns/100ps
module pad_port_mux_tb;
  localparam int unsigned LIMIT = 64;
  localparam int NV = 15;

  // {six, pulses, dir, data, buttons, expected}
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h00, 8'h40, 12'h000, 8'h3F}, // R1 R3
    {1'b0, 2'd0, 8'h00, 8'h40, 12'h015, 8'h2A}, // R1 R3
    {1'b0, 2'd0, 8'h00, 8'h00, 12'h0C2, 8'h01}, // R4
    {1'b0, 2'd0, 8'h00, 8'h00, 12'h000, 8'h33}, // R4
    {1'b0, 2'd3, 8'h00, 8'h00, 12'hF00, 8'h33}, // R8
    {1'b1, 2'd2, 8'h00, 8'h00, 12'h040, 8'h20}, // R5
    {1'b1, 2'd3, 8'h00, 8'h40, 12'hA20, 8'h15}, // R6
    {1'b1, 2'd3, 8'h00, 8'h00, 12'h080, 8'h1F}, // R7
    {1'b1, 2'd2, 8'h00, 8'h40, 12'h000, 8'h3F}, // R8
    {1'b1, 2'd1, 8'h00, 8'h00, 12'h003, 8'h30}, // R8
    {1'b1, 2'd0, 8'h00, 8'h40, 12'hF00, 8'h3F}, // R8
    {1'b0, 2'd0, 8'h0F, 8'hC5, 12'h000, 8'hB5}, // R2
    {1'b0, 2'd0, 8'h40, 8'h40, 12'h000, 8'h7F}, // R11
    {1'b0, 2'd0, 8'h40, 8'h00, 12'h000, 8'h33}, // R11
    {1'b1, 2'd3, 8'h0F, 8'h4A, 12'h000, 8'h3A}  // R2 R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] btn_i = '0;
  logic [7:0]  port_data_i = 8'h40;
  logic [7:0]  port_dir_i = '0;
  logic        six_btn_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic [1:0]  phase_o;
  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pad_port_mux #(.IDLE_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .port_data_i(port_data_i),
    .port_dir_i(port_dir_i), .six_btn_i(six_btn_i), .rd_data_o(rd_data_o),
    .phase_o(phase_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic th_pulse();
    port_data_i[6] = 1'b0;
    @(posedge clk); #1;
    port_data_i[6] = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic th_idle();
    port_data_i[6] = 1'b1;
    repeat (LIMIT + 2) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R12 phase after reset with TH high", {6'b0, phase_o}, 8'h00);
    check("R12 R3 read after reset", rd_data_o, 8'h3F);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      six_btn_i  = v[38];
      port_dir_i = v[35:28];
      btn_i      = v[19:8];
      port_data_i = {v[27], 1'b1, v[25:20]};
      th_idle();
      for (int p = 0; p < int'(v[37:36]); p++) th_pulse();
      port_data_i = v[27:20];
      #1;
      check($sformatf("vector %0d (R1-tagged table, see comment)", i), rd_data_o, v[7:0]);
    end

    six_btn_i = 1'b0; port_dir_i = 8'h00; btn_i = '0;
    th_idle();
    check("R10 phase idle", {6'b0, phase_o}, 8'h00);
    th_pulse();
    check("R9 first rise", {6'b0, phase_o}, 8'h01);
    th_pulse();
    check("R9 second rise", {6'b0, phase_o}, 8'h02);
    port_data_i[6] = 1'b0;
    repeat (3) @(posedge clk); #1;
    check("R9 falling edge holds", {6'b0, phase_o}, 8'h02);
    port_data_i[6] = 1'b1;
    @(posedge clk); #1;
    check("R9 third rise", {6'b0, phase_o}, 8'h03);
    th_pulse();
    check("R9 wrap to 0", {6'b0, phase_o}, 8'h00);

    th_pulse();
    repeat (LIMIT - 1) @(posedge clk);
    #1;
    check("R10 before limit", {6'b0, phase_o}, 8'h01);
    @(posedge clk); #1;
    check("R10 at limit", {6'b0, phase_o}, 8'h00);

    rst_n = 1'b0;
    th_pulse();
    th_pulse();
    check("R12 no counting in reset", {6'b0, phase_o}, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R12 released with TH high", {6'b0, phase_o}, 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule